// File: doc/BRIEF.md
# Sample-Period Interrupt Base Counter

The block counts audio sample periods and interrupts the host after a programmed number of them. A host whose DMA controller keeps no count of its own uses it to learn that a transfer buffer is full. Software writes a 16-bit base count as two bytes. The block keeps a hidden current counter. Each enabled sample period moves that counter one step down. On the enabled period after the counter has reached zero, the block sets an interrupt status bit and reloads the counter from the base bytes.

The status bit is held until software writes the status register. The external interrupt pin follows the status bit only while the interrupt enable is set. Counting runs while playback or capture is enabled. It pauses only when the hold control is set and an interrupt is pending. Counting is the same in programmed-I/O and DMA transfer modes.

Top module: `irq_base_counter`

## Requirements
- R1: After reset both base bytes read as 0x00, the current counter is 0, and the status flag and the pin are low.
- R2: A register write with `reg_sel`=0 stores the lower base byte only and leaves the current counter unchanged.
- R3: A register write with `reg_sel`=1 stores the upper base byte and loads the current counter with {new upper byte, stored lower byte}. The load overrides a tick in the same cycle.
- R4: `reg_rdata` shows the last value written to the byte chosen by `reg_sel` (0 lower, 1 upper). The current counter is never visible there.
- R5: A tick counts only when (`play_en` or `cap_en`) is 1 and (`xfer_hold` is 0 or the status flag is 0).
- R6: A counting tick while the counter is nonzero decrements it by one. A counting tick at zero sets the status flag and reloads the counter from the base bytes, so a base of N gives one underflow every N+1 counting ticks.
- R7: The status flag sets on underflow whatever the value of `irq_en`.
- R8: `irq_pin` equals the status flag ANDed with `irq_en`, with no added delay.
- R9: A pulse on `stat_clr` clears the status flag the next cycle. If an underflow falls in the same cycle, the flag stays set.
- R10: In a cycle without a tick and without an upper-byte write, the current counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Base byte write strobe |
| reg_sel | input | 1 | Byte select: 0 lower, 1 upper |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Selected base byte |
| stat_clr | input | 1 | Status write strobe, clears the flag |
| tick | input | 1 | One-cycle pulse per sample period |
| play_en | input | 1 | Playback enabled |
| cap_en | input | 1 | Capture enabled |
| xfer_hold | input | 1 | Hold counting while an interrupt is pending |
| irq_en | input | 1 | Interrupt pin enable |
| irq_flag | output | 1 | Interrupt status bit |
| irq_pin | output | 1 | External interrupt pin |

## Verification
On every cycle the assertions check the step-by-step rules of the hidden counter: it holds, decrements, reloads and loads as required. They also check that set wins over clear on the flag, and that a lower-byte write leaves the upper byte alone. The bench can only see the counter through the timing of the flag, so the bench scenarios are what show the end-to-end behaviour. These are the N+1 period for each small base, all sixteen control combinations, the pause caused by hold with a pending flag, a lower-byte write in the middle of a count, a load that collides with a tick, and a clear that collides with an underflow.

// File: rtl/ibc_pkg.sv
// Shared types for the sample-period interrupt base counter.
// Assumes the count width is a whole number of register bytes.
package ibc_pkg;
    // Per-sample control bits, grouped as one value inside the block.
    typedef struct packed {
        logic play;
        logic cap;
        logic hold;
        logic ien;
    } ibc_ctrl_t;
endpackage

// File: rtl/ibc_base_regs.sv
// Base count byte registers. Holds NBYTES software-written bytes and
// returns the selected one on read. A write to the top byte is the commit
// point: it produces a load strobe and the full base value that includes
// the new byte. Assumes sel never exceeds NBYTES-1.
module ibc_base_regs #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    localparam int NBYTES = CNT_W / BYTE_W,
    localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [CNT_W-1:0]  base_val,
    output logic              commit,
    output logic [CNT_W-1:0]  commit_val
);
    logic [BYTE_W-1:0] byte_q [NBYTES];

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        // Store one base byte on a write addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q[i] <= '0;
            else if (wr && sel == SEL_W'(i))
                byte_q[i] <= wdata;
        end
        assign base_val[i*BYTE_W +: BYTE_W] = byte_q[i];
    end

    // Commit strobe and the value that the counter takes on a commit.
    always_comb begin
        commit     = wr && (sel == SEL_W'(NBYTES - 1));
        commit_val = base_val;
        commit_val[CNT_W-1 -: BYTE_W] = wdata;
    end

    // Read mux over the stored bytes.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NBYTES; k++)
            if (sel == SEL_W'(k))
                rdata = byte_q[k];
    end

    // A lower-byte write leaves the committing byte unchanged.
    AST_LOWER_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel != SEL_W'(NBYTES - 1)) |=> $stable(byte_q[NBYTES-1])); // R2
    // An upper-byte write takes the written data.
    AST_UPPER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (byte_q[NBYTES-1] == $past(wdata))); // R3
endmodule

// File: rtl/ibc_down_counter.sv
// Hidden current counter. A commit load has priority. Otherwise an enabled
// tick decrements the counter, or, at zero, reloads it from the base and
// raises a one-cycle underflow pulse. Assumes tick is a one-cycle pulse.
module ibc_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] base_val,
    output logic             underflow
);
    logic [CNT_W-1:0] cur_q;
    logic             step;
    logic             at_zero;

    // Decide whether this cycle counts and whether it underflows.
    always_comb begin
        step      = tick && cnt_en && !load;
        at_zero   = (cur_q == '0);
        underflow = step && at_zero;
    end

    // Load, reload or decrement the current count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= '0;
        else if (load)
            cur_q <= load_val;
        else if (step)
            cur_q <= at_zero ? base_val : cur_q - 1'b1;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_q == $past(load_val))); // R3
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_en && !load && cur_q != '0) |=> (cur_q == $past(cur_q) - 1'b1)); // R6
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_en && !load && cur_q == '0) |=> (cur_q == $past(base_val))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cur_q)); // R10
    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !load) |=> $stable(cur_q)); // R5
endmodule

// File: rtl/ibc_irq_status.sv
// Interrupt status bit and pin. Underflow sets the bit and a status write
// clears it; the set wins when both arrive together. The pin is the bit
// gated by the enable, so masking never hides a pending status.
module ibc_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic ien,
    output logic flag,
    output logic pin
);
    logic flag_q;

    // Sticky status bit with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set)
            flag_q <= 1'b1;
        else if (clr)
            flag_q <= 1'b0;
    end

    // Drive the status and the masked pin.
    always_comb begin
        flag = flag_q;
        pin  = flag_q && ien;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag); // R9
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !set) |=> !flag); // R6
endmodule

// File: rtl/irq_base_counter.sv
// Top of the sample-period interrupt base counter. Joins the base byte
// registers, the hidden down counter and the interrupt status. Computes
// the count gate from the control bits and the pending status.
// Assumes tick, reg_wr and stat_clr are synchronous one-cycle strobes.
module irq_base_counter #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    localparam int NBYTES = CNT_W / BYTE_W,
    localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              stat_clr,
    input  logic              tick,
    input  logic              play_en,
    input  logic              cap_en,
    input  logic              xfer_hold,
    input  logic              irq_en,
    output logic              irq_flag,
    output logic              irq_pin
);
    import ibc_pkg::*;

    ibc_ctrl_t        ctrl;
    logic [CNT_W-1:0] base_val;
    logic [CNT_W-1:0] commit_val;
    logic             commit;
    logic             cnt_en;
    logic             underflow;
    logic             flag;

    // Group the control inputs and form the count gate.
    always_comb begin
        ctrl   = '{play: play_en, cap: cap_en, hold: xfer_hold, ien: irq_en};
        cnt_en = (ctrl.play || ctrl.cap) && (!ctrl.hold || !flag);
    end

    ibc_base_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .base_val   (base_val),
        .commit     (commit),
        .commit_val (commit_val)
    );

    ibc_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cnt_en    (cnt_en),
        .load      (commit),
        .load_val  (commit_val),
        .base_val  (base_val),
        .underflow (underflow)
    );

    ibc_irq_status u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (underflow),
        .clr   (stat_clr),
        .ien   (ctrl.ien),
        .flag  (flag),
        .pin   (irq_pin)
    );

    assign irq_flag = flag;

    // A pending interrupt under hold freezes the flag unless cleared.
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_hold && flag && !stat_clr) |=> flag); // R5
    // The pin never rises without a pending status.
    AST_PIN_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pin |-> irq_flag); // R8
endmodule

// File: tb/irq_base_counter_test.sv
// Self-checking bench: a small reference model of the requirements, swept
// over small base values and every control combination.
module irq_base_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [0:0] reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       stat_clr = 1'b0;
    logic       tick = 1'b0;
    logic       play_en = 1'b0;
    logic       cap_en = 1'b0;
    logic       xfer_hold = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq_flag;
    logic       irq_pin;

    int vectors = 0;
    int fails = 0;

    // Reference state, following the requirements.
    logic [15:0] m_cur = 16'h0;
    logic [7:0]  m_lo = 8'h0;
    logic [7:0]  m_hi = 8'h0;
    logic        m_flag = 1'b0;

    always #2 clk = ~clk;

    irq_base_counter uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_clr(stat_clr),
        .tick(tick), .play_en(play_en), .cap_en(cap_en),
        .xfer_hold(xfer_hold), .irq_en(irq_en), .irq_flag(irq_flag),
        .irq_pin(irq_pin)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One clock cycle: drive at the falling edge, update the model at the
    // rising edge, compare shortly after it.
    task automatic cyc(input logic wr, input logic sel, input logic [7:0] d,
                       input logic clr, input logic tk, input string tag);
        logic load, en, set;
        logic [15:0] nxt;
        @(negedge clk);
        reg_wr = wr; reg_sel = sel; reg_wdata = d; stat_clr = clr; tick = tk;
        @(posedge clk);
        load = wr && sel;
        en   = (play_en || cap_en) && (!xfer_hold || !m_flag);
        set  = 1'b0;
        nxt  = m_cur;
        if (load) nxt = {d, m_lo};                         // R3
        else if (tk && en) begin
            if (m_cur == 16'h0) begin set = 1'b1; nxt = {m_hi, m_lo}; end  // R6
            else nxt = m_cur - 16'h1;
        end
        m_cur = nxt;
        if (wr && sel) m_hi = d;
        if (wr && !sel) m_lo = d;                          // R2
        if (set) m_flag = 1'b1; else if (clr) m_flag = 1'b0;  // R9
        #1;
        check(tag, {7'h0, irq_flag}, {7'h0, m_flag});
        check("R8", {7'h0, irq_pin}, {7'h0, m_flag & irq_en});
        check("R4", reg_rdata, sel ? m_hi : m_lo);
    endtask

    task automatic load_base(input logic [15:0] b);
        cyc(1'b1, 1'b0, b[7:0], 1'b0, 1'b0, "R2");
        cyc(1'b1, 1'b1, b[15:8], 1'b0, 1'b0, "R3");
        cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R9");
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", {7'h0, irq_flag}, 8'h00);
        check("R1", {7'h0, irq_pin}, 8'h00);
        check("R1", reg_rdata, 8'h00);
        cyc(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R1");
        // R1: counter is zero, so the first counting tick underflows
        play_en = 1'b1;
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R1");
        check("R1", {7'h0, irq_flag}, 8'h01);

        // R4: read back both bytes
        cyc(1'b1, 1'b0, 8'hA5, 1'b1, 1'b0, "R9");
        cyc(1'b1, 1'b1, 8'h3C, 1'b0, 1'b0, "R3");
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R4");
        cyc(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R4");

        // R5 R6 R7 R10: sweep base 0..5 across all control combinations
        for (int b = 0; b < 6; b++) begin
            for (int c = 0; c < 16; c++) begin
                play_en = 1'b1; cap_en = 1'b0; xfer_hold = 1'b0; irq_en = 1'b0;
                load_base(16'(b));
                {play_en, cap_en, xfer_hold, irq_en} = 4'(c);
                for (int t = 0; t < 2 * (b + 1) + 3; t++) begin
                    cyc(1'b0, t[0], 8'h00, 1'b0, 1'b1, "R6");
                    if (t % 3 == 2) cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R10");
                end
                // clear under hold and check counting resumes
                cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R9");
                for (int t = 0; t < b + 2; t++)
                    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R5");
            end
        end

        // R7: flag sets with the pin masked
        play_en = 1'b1; cap_en = 1'b0; xfer_hold = 1'b0; irq_en = 1'b0;
        load_base(16'd2);
        for (int t = 0; t < 3; t++) cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R7");
        check("R7", {7'h0, irq_flag}, 8'h01);
        irq_en = 1'b1;
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R8");

        // R6: larger base 258 counts 259 ticks per underflow
        load_base(16'h0102);
        for (int t = 0; t < 260; t++) cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R6");

        // R2: a lower write mid-count does not disturb the running count
        load_base(16'd4);
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R2");
        cyc(1'b1, 1'b0, 8'h09, 1'b0, 1'b1, "R2");
        for (int t = 0; t < 14; t++) cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R2");

        // R3: upper write collides with a tick at zero; the load wins
        load_base(16'd0);
        cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, "R3");
        cyc(1'b1, 1'b0, 8'h02, 1'b0, 1'b0, "R3");
        cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, "R3");
        for (int t = 0; t < 4; t++) cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R3");

        // R9: clear in the same cycle as an underflow keeps the flag set
        load_base(16'd0);
        cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R9");
        check("R9", {7'h0, irq_flag}, 8'h01);
        cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R9");
        check("R9", {7'h0, irq_flag}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule